// File: doc/BRIEF.md
# Audio DAC Power Sequencer

This block brings the control side of an audio converter up and down in a safe order. It watches a master clock and a frame clock and measures how many master-clock cycles fit in one frame. If the ratio is one the converter supports, it powers the voltage reference, then the converters and the switched filter. The analog output is held at ground for a set number of frames and then raised along a ramp, one step per frame. Audio is released only after the ramp ends.

All logic runs on one free-running reference clock. Both audio clocks are sampled into that domain through two-flop synchronizers. The reference clock must run more than twice as fast as the master clock. If either audio clock makes no edge within a set number of reference cycles, that clock counts as lost. Every enable then drops, the output buffers are released, and a soft discharge sink takes their place. The next return of both clocks starts the sequence again from measurement. The analog ramp, the sink and the filters are outside this block; it drives only their control lines.

Top module: `dac_pwr_seq`

## Requirements
- R1: In power-down the block holds these values: `filtRst`=1, `sinkEn`=1, `refEn`=0, `dacEn`=0, `filtEn`=0, `outClamp`=0, `audioOk`=0 and `rampLevel`=0. This holds after reset and whenever either audio clock is missing.
- R2: A clock counts as present once an edge of it has been seen. It counts as missing when MISS_CYCLES reference cycles pass with no edge on it, and not before.
- R3: With both clocks present, the block counts master-clock rising edges between two frame-clock rising edges. It presents that count on `ratio` and holds it until the next measurement.
- R4: Only the ratios 256, 384 and 512 are accepted. Any other ratio sets `ratioErr`=1 and keeps all enables at 0 with `sinkEn`=1, until a clock is lost. Power-down clears `ratioErr`.
- R5: After a good measurement `refEn` rises first. REF_PERIODS frames later, `dacEn` and `filtEn` rise together and `filtRst` falls. `dacEn` is never 1 while `refEn` is 0.
- R6: `outClamp` is 1 from the start of measurement until HOLD_PERIODS frames after `dacEn` rises. It is then released.
- R7: After the clamp is released, `rampLevel` rises by one on each frame for RAMP_PERIODS frames. `audioOk` then rises with `rampLevel` equal to RAMP_PERIODS. `rampLevel` never changes except by +1 or back to 0.
- R8: When a clock is declared missing, whatever the state, all enables and `audioOk` fall and `sinkEn` rises on the next reference cycle.
- R9: When both clocks return after a power-down, the full sequence runs again from measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| mclkIn | input | 1 | Master audio clock, asynchronous |
| lrckIn | input | 1 | Frame (left/right) clock, asynchronous |
| refEn | output | 1 | Voltage reference enable |
| dacEn | output | 1 | Converter enable |
| filtEn | output | 1 | Switched-capacitor filter enable |
| filtRst | output | 1 | Interpolator and modulator reset |
| outClamp | output | 1 | Clamp the outputs to ground |
| sinkEn | output | 1 | Discharge sink in place of the outputs |
| audioOk | output | 1 | Audio output released |
| rampLevel | output | LEVEL_W | Output ramp level code |
| ratio | output | RATIO_W | Measured master/frame clock ratio |
| ratioErr | output | 1 | Measured ratio is unsupported |

## Verification
The bench builds the block with MISS_CYCLES=1200, REF_PERIODS=2, HOLD_PERIODS=3 and RAMP_PERIODS=6. With these values full sequences at ratios 512, 384 and 256 fit in one run, along with a rejected ratio of 128. MISS_CYCLES is set just above the longest frame-clock half period (1024 reference cycles at ratio 512). The bench therefore stalls the frame clock mid-ramp and samples the outputs on both sides of the loss threshold. A scoreboard compares, for each completed sequence, the ratio and the number of frames in each phase with the values pushed by the driver.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_MEAS,
    ST_BAD,
    ST_REF,
    ST_HOLD,
    ST_RAMP,
    ST_RUN
  } seqState_t;

  typedef enum logic [1:0] {
    LIM_REF,
    LIM_HOLD,
    LIM_RAMP
  } limSel_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic    measEn;
    logic    cntClr;
    logic    levelClr;
    logic    levelInc;
    limSel_t limSel;
  } dpStrobe_t;

  typedef struct packed {
    logic refEn;
    logic dacEn;
    logic filtEn;
    logic filtRst;
    logic outClamp;
    logic sinkEn;
    logic audioOk;
    logic ratioErr;
  } seqOut_t;

  function automatic logic ratioSupported(input int unsigned r);
    return (r == 256) || (r == 384) || (r == 512);
  endfunction

endpackage

// File: rtl/dps_clk_watch.sv
module dps_clk_watch #(
  parameter int MISS_CYCLES = 4096
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic rise,
  output logic present
);
  localparam int TW = $clog2(MISS_CYCLES + 1);
  localparam logic [TW-1:0] MISS_L = TW'(MISS_CYCLES);

  logic sync1, sync2, sync3;
  logic toggle;
  logic [TW-1:0] idleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= rawIn;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign toggle = sync2 ^ sync3;
  assign rise   = sync2 & ~sync3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= MISS_L;
    end else if (toggle) begin
      idleCnt <= '0;
    end else if (idleCnt != MISS_L) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign present = (idleCnt != MISS_L);

  AST_EDGE_MEANS_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    toggle |=> present); // R2

endmodule

// File: rtl/dps_dpath.sv
module dps_dpath
  import dps_pkg::*;
#(
  parameter int RATIO_W      = 11,
  parameter int LEVEL_W      = 14,
  parameter int REF_PERIODS  = 4,
  parameter int HOLD_PERIODS = 1000,
  parameter int RAMP_PERIODS = 10000
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic               mclkRise,
  input  logic               lrckRise,
  output logic [RATIO_W-1:0] ratio,
  output logic               ratioValid,
  output logic               ratioOk,
  output logic               frameDone,
  output logic [LEVEL_W-1:0] level
);
  localparam int MAXP  = (RAMP_PERIODS > HOLD_PERIODS) ?
                         ((RAMP_PERIODS > REF_PERIODS) ? RAMP_PERIODS : REF_PERIODS) :
                         ((HOLD_PERIODS > REF_PERIODS) ? HOLD_PERIODS : REF_PERIODS);
  localparam int CNT_W = $clog2(MAXP + 1);
  localparam logic [CNT_W-1:0] REF_L  = CNT_W'(REF_PERIODS);
  localparam logic [CNT_W-1:0] HOLD_L = CNT_W'(HOLD_PERIODS);
  localparam logic [CNT_W-1:0] RAMP_L = CNT_W'(RAMP_PERIODS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [LEVEL_W-1:0] LEVEL_MAX = '1;
  localparam logic [RATIO_W-1:0] RATIO_MAX = '1;

  // ratio measurement
  logic               measArmed;
  logic [RATIO_W-1:0] mclkCnt;
  logic [RATIO_W:0]   cntNext;

  assign cntNext = {1'b0, mclkCnt} + {{RATIO_W{1'b0}}, mclkRise};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      measArmed  <= 1'b0;
      mclkCnt    <= '0;
      ratio      <= '0;
      ratioValid <= 1'b0;
    end else begin
      ratioValid <= 1'b0;
      if (!stb.measEn) begin
        measArmed <= 1'b0;
        mclkCnt   <= '0;
      end else if (lrckRise) begin
        if (measArmed) begin
          ratio      <= cntNext[RATIO_W] ? RATIO_MAX : cntNext[RATIO_W-1:0];
          ratioValid <= 1'b1;
        end
        measArmed <= 1'b1;
        mclkCnt   <= '0;
      end else if (mclkRise && measArmed && (mclkCnt != RATIO_MAX)) begin
        mclkCnt <= mclkCnt + 1'b1;
      end
    end
  end

  assign ratioOk = ratioSupported(32'(ratio));

  // phase frame counter shared by all timed states
  logic [CNT_W-1:0] frameCnt;
  logic [CNT_W-1:0] limit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
    end else if (stb.cntClr) begin
      frameCnt <= '0;
    end else if (lrckRise && (frameCnt != CNT_MAX)) begin
      frameCnt <= frameCnt + 1'b1;
    end
  end

  always_comb begin
    case (stb.limSel)
      LIM_REF:  limit = REF_L;
      LIM_HOLD: limit = HOLD_L;
      default:  limit = RAMP_L;
    endcase
  end

  assign frameDone = (frameCnt >= limit);

  // output ramp level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      level <= '0;
    end else if (stb.levelClr) begin
      level <= '0;
    end else if (stb.levelInc && lrckRise && (level != LEVEL_MAX)) begin
      level <= level + 1'b1;
    end
  end

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (level != $past(level)) |-> ((level == $past(level) + 1'b1) || (level == '0))); // R7

  AST_RATIO_FROM_MEAS: assert property (@(posedge clk) disable iff (!rstN)
    ratioValid |-> $past(stb.measEn)); // R3

endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      clocksOk,
  input  logic      ratioValid,
  input  logic      ratioOk,
  input  logic      frameDone,
  output dpStrobe_t stb,
  output seqOut_t   outs
);
  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    if (!clocksOk) begin
      nextState = ST_OFF;
    end else begin
      case (state)
        ST_OFF:  nextState = ST_MEAS;
        ST_MEAS: if (ratioValid) nextState = ratioOk ? ST_REF : ST_BAD;
        ST_BAD:  nextState = ST_BAD;
        ST_REF:  if (frameDone) nextState = ST_HOLD;
        ST_HOLD: if (frameDone) nextState = ST_RAMP;
        ST_RAMP: if (frameDone) nextState = ST_RUN;
        ST_RUN:  nextState = ST_RUN;
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    stb.measEn   = (state == ST_MEAS);
    stb.cntClr   = (nextState != state);
    stb.levelClr = (state == ST_OFF) || (state == ST_MEAS) || (state == ST_BAD);
    stb.levelInc = (state == ST_RAMP);
    case (state)
      ST_REF:  stb.limSel = LIM_REF;
      ST_HOLD: stb.limSel = LIM_HOLD;
      default: stb.limSel = LIM_RAMP;
    endcase
  end

  function automatic seqOut_t decode(input seqState_t s);
    seqOut_t o;
    o = '0;
    case (s)
      ST_MEAS: begin o.filtRst = 1'b1; o.outClamp = 1'b1; end
      ST_BAD:  begin o.filtRst = 1'b1; o.sinkEn = 1'b1; o.ratioErr = 1'b1; end
      ST_REF:  begin o.refEn = 1'b1; o.filtRst = 1'b1; o.outClamp = 1'b1; end
      ST_HOLD: begin o.refEn = 1'b1; o.dacEn = 1'b1; o.filtEn = 1'b1; o.outClamp = 1'b1; end
      ST_RAMP: begin o.refEn = 1'b1; o.dacEn = 1'b1; o.filtEn = 1'b1; end
      ST_RUN:  begin o.refEn = 1'b1; o.dacEn = 1'b1; o.filtEn = 1'b1; o.audioOk = 1'b1; end
      default: begin o.filtRst = 1'b1; o.sinkEn = 1'b1; end
    endcase
    return o;
  endfunction

  // outputs registered from the next state: no decode glitches at the pins
  always_ff @(posedge clk) begin
    if (!rstN) outs <= decode(ST_OFF);
    else       outs <= decode(nextState);
  end

  AST_REF_BEFORE_DAC: assert property (@(posedge clk) disable iff (!rstN)
    outs.dacEn |-> outs.refEn); // R5

  AST_BAD_RATIO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    outs.ratioErr |-> (!outs.refEn && !outs.dacEn && outs.sinkEn)); // R4

  AST_LOSS_POWERDOWN: assert property (@(posedge clk) disable iff (!rstN)
    !clocksOk |=> (!outs.refEn && !outs.dacEn && !outs.filtEn && outs.filtRst
                   && outs.sinkEn && !outs.audioOk)); // R8

  AST_CLAMP_AT_DAC_ON: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outs.dacEn) |-> outs.outClamp); // R6

endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
  import dps_pkg::*;
#(
  parameter int MISS_CYCLES  = 4096,
  parameter int RATIO_W      = 11,
  parameter int LEVEL_W      = 14,
  parameter int REF_PERIODS  = 4,
  parameter int HOLD_PERIODS = 1000,
  parameter int RAMP_PERIODS = 10000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mclkIn,
  input  logic               lrckIn,
  output logic               refEn,
  output logic               dacEn,
  output logic               filtEn,
  output logic               filtRst,
  output logic               outClamp,
  output logic               sinkEn,
  output logic               audioOk,
  output logic [LEVEL_W-1:0] rampLevel,
  output logic [RATIO_W-1:0] ratio,
  output logic               ratioErr
);
  localparam int NCLK = 2;

  logic [NCLK-1:0] rawClk, clkRise, clkPresent;
  assign rawClk = {lrckIn, mclkIn};

  for (genvar i = 0; i < NCLK; i++) begin : gWatch
    dps_clk_watch #(.MISS_CYCLES(MISS_CYCLES)) uWatch (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawClk[i]),
      .rise   (clkRise[i]),
      .present(clkPresent[i])
    );
  end

  logic      clocksOk, ratioValid, ratioOk, frameDone;
  dpStrobe_t stb;
  seqOut_t   outs;

  assign clocksOk = &clkPresent;

  dps_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .clocksOk  (clocksOk),
    .ratioValid(ratioValid),
    .ratioOk   (ratioOk),
    .frameDone (frameDone),
    .stb       (stb),
    .outs      (outs)
  );

  dps_dpath #(
    .RATIO_W     (RATIO_W),
    .LEVEL_W     (LEVEL_W),
    .REF_PERIODS (REF_PERIODS),
    .HOLD_PERIODS(HOLD_PERIODS),
    .RAMP_PERIODS(RAMP_PERIODS)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .mclkRise  (clkRise[0]),
    .lrckRise  (clkRise[1]),
    .ratio     (ratio),
    .ratioValid(ratioValid),
    .ratioOk   (ratioOk),
    .frameDone (frameDone),
    .level     (rampLevel)
  );

  assign refEn    = outs.refEn;
  assign dacEn    = outs.dacEn;
  assign filtEn   = outs.filtEn;
  assign filtRst  = outs.filtRst;
  assign outClamp = outs.outClamp;
  assign sinkEn   = outs.sinkEn;
  assign audioOk  = outs.audioOk;
  assign ratioErr = outs.ratioErr;

  AST_AUDIO_AT_FULL_RAMP: assert property (@(posedge clk) disable iff (!rstN)
    audioOk |-> (rampLevel == LEVEL_W'(RAMP_PERIODS))); // R7

endmodule

// File: tb/sim_dac_pwr_seq.sv
module sim_dac_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MISS  = 1200;
  localparam int REFP  = 2;
  localparam int HOLDP = 3;
  localparam int RAMPP = 6;
  localparam int WDOG  = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mclk = 1'b0;
  logic lrck = 1'b0;
  logic refEn, dacEn, filtEn, filtRst, outClamp, sinkEn, audioOk, ratioErr;
  logic [13:0] rampLevel;
  logic [10:0] ratio;

  dac_pwr_seq #(
    .MISS_CYCLES(MISS), .RATIO_W(11), .LEVEL_W(14),
    .REF_PERIODS(REFP), .HOLD_PERIODS(HOLDP), .RAMP_PERIODS(RAMPP)
  ) u0 (
    .clk(clk), .rstN(rstN), .mclkIn(mclk), .lrckIn(lrck),
    .refEn(refEn), .dacEn(dacEn), .filtEn(filtEn), .filtRst(filtRst),
    .outClamp(outClamp), .sinkEn(sinkEn), .audioOk(audioOk),
    .rampLevel(rampLevel), .ratio(ratio), .ratioErr(ratioErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // master clock: edges fall 3 time units off the reference grid
  bit mclkRun = 1'b0;
  bit lrckRun = 1'b0;
  int ratioSet = 512;
  int divCnt = 0;

  initial begin
    #3;
    forever begin
      #(2*CLK_PERIOD);
      if (mclkRun) mclk = ~mclk;
    end
  end

  always @(posedge mclk) begin
    if (lrckRun) begin
      divCnt++;
      if (divCnt >= ratioSet/2) begin
        lrck = ~lrck;
        divCnt = 0;
      end
    end
  end

  int lrckRises = 0;
  always @(posedge lrck) lrckRises++;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    int ratio;
    int refF;
    int holdF;
    int rampF;
  } item_t;
  item_t expQ[$];

  logic pRef = 1'b0, pDac = 1'b0, pClamp = 1'b0, pAud = 1'b0;
  int mark = 0, gotRef = 0, gotHold = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (refEn && !pRef) mark = lrckRises;
      if (dacEn && !pDac) begin
        gotRef = lrckRises - mark;
        mark = lrckRises;
        check("R5", "filtEn at converter enable", int'(filtEn), 1);
        check("R5", "filtRst at converter enable", int'(filtRst), 0);
        check("R6", "clamp at converter enable", int'(outClamp), 1);
      end
      if (!outClamp && pClamp && dacEn) begin
        gotHold = lrckRises - mark;
        mark = lrckRises;
      end
      if (audioOk && !pAud) begin
        if (expQ.size() == 0) begin
          check("R7", "unexpected audio release", 1, 0);
        end else begin
          item_t e;
          e = expQ.pop_front();
          check("R3", "measured ratio", int'(ratio), e.ratio);
          check("R5", "reference-only frames", gotRef, e.refF);
          check("R6", "clamp hold frames", gotHold, e.holdF);
          check("R7", "ramp frames", lrckRises - mark, e.rampF);
          check("R7", "level at audio release", int'(rampLevel), e.rampF);
        end
      end
    end
    pRef = refEn; pDac = dacEn; pClamp = outClamp; pAud = audioOk;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushRun(input int r);
    item_t e;
    e.ratio = r; e.refF = REFP; e.holdF = HOLDP; e.rampF = RAMPP;
    expQ.push_back(e);
  endtask

  task automatic waitAudio(input string req);
    int n = 0;
    while (!audioOk && n < 70000) begin
      @(negedge clk);
      n++;
    end
    check(req, "audio released", int'(audioOk), 1);
  endtask

  task automatic checkOff(input string req);
    check(req, "refEn off", int'(refEn), 0);
    check(req, "dacEn off", int'(dacEn), 0);
    check(req, "filtEn off", int'(filtEn), 0);
    check(req, "filtRst on", int'(filtRst), 1);
    check(req, "sinkEn on", int'(sinkEn), 1);
    check(req, "clamp off", int'(outClamp), 0);
    check(req, "audioOk off", int'(audioOk), 0);
    check("R1", "level cleared", int'(rampLevel), 0);
  endtask

  task automatic stopClocks();
    mclkRun = 1'b0;
    cycles(MISS + 100);
  endtask

  initial begin
    cycles(5);
    checkOff("R1");
    check("R1", "ratioErr at reset", int'(ratioErr), 0);
    rstN = 1'b1;
    cycles(3);
    checkOff("R1");

    // full sequence at 512
    ratioSet = 512;
    pushRun(512);
    lrckRun = 1'b1;
    mclkRun = 1'b1;
    waitAudio("R7");
    cycles(50);
    check("R7", "level holds in run", int'(rampLevel), RAMPP);

    // master clock lost while audio is playing
    stopClocks();
    checkOff("R8");

    // 384: stall frame clock mid-ramp
    ratioSet = 384;
    mclkRun = 1'b1;
    while (!(dacEn && !outClamp)) @(negedge clk);
    @(posedge lrck);
    @(posedge lrck);
    lrckRun = 1'b0;
    cycles(1000);
    check("R2", "still ramping before loss threshold", int'(dacEn), 1);
    check("R2", "no sink before loss threshold", int'(sinkEn), 0);
    check("R7", "level after two ramp frames", int'(rampLevel), 2);
    cycles(300);
    checkOff("R8");

    // frame clock returns: sequence restarts from measurement
    pushRun(384);
    lrckRun = 1'b1;
    waitAudio("R9");

    stopClocks();
    checkOff("R8");

    // 256
    ratioSet = 256;
    pushRun(256);
    mclkRun = 1'b1;
    waitAudio("R7");
    stopClocks();
    checkOff("R8");

    // unsupported ratio 128
    ratioSet = 128;
    mclkRun = 1'b1;
    cycles(5000);
    check("R3", "ratio 128 measured", int'(ratio), 128);
    check("R4", "ratioErr set", int'(ratioErr), 1);
    check("R4", "reference stays off", int'(refEn), 0);
    check("R4", "sink stays on", int'(sinkEn), 1);
    stopClocks();
    check("R4", "ratioErr cleared by power-down", int'(ratioErr), 0);
    checkOff("R8");

    check("R9", "scoreboard drained", expQ.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d cycles", WDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule